// File: doc/BRIEF.md
# Exception Entry Sequencer

This block turns a set of pending exception requests into the register updates a processor core makes when it enters an exception handler. When the core pulses the entry strobe, the sequencer selects one eligible cause by fixed priority and, on that same clock edge, loads four registers. The saved program counter holds the address the handler returns to. The saved state word holds the old machine state with cause information merged into it. The new machine-state word is the one the handler runs with. The vector register holds the handler address. A one-cycle `taken_o` pulse marks the entry.

The block also builds the data-fault status word from a two-bit translation fault code and a store flag. It loads that word only on a data-fault entry. Maskable external and decrementer requests are not accepted while interrupt enable is clear. The block never clears a request input, so a request the requester keeps asserting is taken at a later strobe once interrupts are enabled.

A two-state controller governs the output registers. In `ST_IDLE`, no entry happened at the last edge. In `ST_ENTERED`, an entry was loaded at the last edge and `taken_o` is high. The transition `ACCEPT` happens when the strobe sees at least one eligible cause, and it leads from either state to `ST_ENTERED`. The transition `RELAX` leads from `ST_ENTERED` back to `ST_IDLE` on any other edge. `ST_IDLE` stays in `ST_IDLE` without a strobe.

Top module: `exc_entry_seq`

## Requirements
- R1: The request bits are reset 0, machine check 1, data fault 2, instruction fault 3, external 4, alignment 5, program 6, FP unavailable 7, decrementer 8 and system call 9. Their vectors are 0x100, 0x200, 0x300, 0x400, 0x500, 0x600, 0x700, 0x800, 0x900 and 0xC00 in the same order.
- R2: Among eligible requests, priority runs from highest to lowest as follows: reset, machine check, instruction fault, data fault, alignment, program, FP unavailable, system call, external, decrementer. An ineligible request never blocks a lower one.
- R3: The saved PC is the next PC for reset, data fault, instruction fault, external, decrementer and system call. It is next PC minus 4 for machine check, alignment, program and FP unavailable.
- R4: The saved state is the incoming machine state. For data fault, instruction fault, program and FP unavailable, bits [31:16] are cleared first. For an instruction fault, the fault status word is then ORed in.
- R5: A program entry ORs 0x00010000 into the saved state, together with one bit chosen by prog_kind_i: 0 (FP enabled) sets 0x00100000, 1 (illegal) sets 0x00080000, 2 (privileged) sets 0x00040000, and 3 (trap) sets 0x00020000.
- R6: A program request with prog_kind_i = 0 is not eligible when machine-state bits FE0 (bit 11) and FE1 (bit 8) are both zero.
- R7: External and decrementer requests are eligible only while machine-state bit 15 (interrupt enable) is 1. A masked-only strobe changes no output, and the same request is taken at a later strobe once the bit is 1.
- R8: The new machine state is the incoming one with bits 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 cleared (mask 0xEF32) and bit 0 copied from bit 16.
- R9: A machine check is eligible only when bit 12 (ME) is set. Its entry also clears bit 12 in the new machine state.
- R10: Fault status codes are 1 → 0x40000000, 2 → 0x08000000, 3 → 0x10000000 and 0 → 0. The data-fault status register loads that code, ORed with 0x02000000 when fault_store_i is 1, only on a data-fault entry, and holds its value otherwise.
- R11: All outputs load at the clock edge where the strobe sees an eligible cause, and taken_o is high for the following cycle only. Without such an edge, every output holds its value and taken_o is 0.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| entry_stb_i | input | 1 | Entry strobe from the core |
| req_i | input | 10 | Pending cause requests (bit map in R1) |
| prog_kind_i | input | 2 | Program exception sub-cause |
| fault_code_i | input | 2 | Translation fault code |
| fault_store_i | input | 1 | Faulting data access was a store |
| pc_next_i | input | 32 | Address of the next instruction |
| msr_i | input | 32 | Current machine-state word |
| taken_o | output | 1 | One-cycle entry pulse |
| vector_o | output | 32 | Handler vector address |
| srr0_o | output | 32 | Saved program counter |
| srr1_o | output | 32 | Saved state word |
| msr_new_o | output | 32 | Machine-state word for the handler |
| dsisr_o | output | 32 | Data-fault status word |

## Verification
Every result is due exactly one clock edge after the strobe that is sampled with the inputs. The registers load at that edge, and the pulse and values are visible until the next edge. The bench drives stimulus on falling edges. Its behavioural model updates its expected values at each rising edge from the same sampled inputs, and all six outputs are compared at the next falling edge, every cycle. Idle and masked cycles therefore also confirm that the registers hold and that the pulse is absent.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN   = 32;
    localparam int NCAUSE = 10;
    localparam int CW     = $clog2(NCAUSE);

    typedef enum logic [CW-1:0] {
        C_RESET = 4'd0, C_MCHK  = 4'd1, C_DFAULT = 4'd2, C_IFAULT = 4'd3,
        C_EXT   = 4'd4, C_ALIGN = 4'd5, C_PROG   = 4'd6, C_FPUN   = 4'd7,
        C_DEC   = 4'd8, C_SCALL = 4'd9
    } cause_e;

    // machine-state bit positions
    localparam int B_LE  = 0;
    localparam int B_FE1 = 8;
    localparam int B_FE0 = 11;
    localparam int B_ME  = 12;
    localparam int B_EE  = 15;
    localparam int B_ILE = 16;
    localparam logic [XLEN-1:0] ENTRY_CLR = 32'h0000_EF32;
    localparam logic [XLEN-1:0] LOW_HALF  = 32'h0000_FFFF;
    localparam logic [XLEN-1:0] PROG_BASE = 32'h0001_0000;
    localparam logic [XLEN-1:0] STORE_BIT = 32'h0200_0000;

    // highest priority first
    localparam logic [CW-1:0] PRIO [NCAUSE] = '{
        4'd0, 4'd1, 4'd3, 4'd2, 4'd5, 4'd6, 4'd7, 4'd9, 4'd4, 4'd8
    };

    function automatic logic [XLEN-1:0] vec_of(input cause_e c);
        logic [XLEN-1:0] v;
        unique case (c)
            C_SCALL: v = 32'h0000_0C00;
            default: v = XLEN'({c, 8'h00}) + 32'h0000_0100;
        endcase
        return v;
    endfunction

    function automatic logic [XLEN-1:0] fault_word(input logic [1:0] code);
        logic [XLEN-1:0] w;
        unique case (code)
            2'd1:    w = 32'h4000_0000;
            2'd2:    w = 32'h0800_0000;
            2'd3:    w = 32'h1000_0000;
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic logic [XLEN-1:0] prog_bit(input logic [1:0] kind);
        return XLEN'(32'h0010_0000 >> kind);
    endfunction

    function automatic logic saves_current(input cause_e c);
        return (c == C_MCHK) || (c == C_ALIGN) || (c == C_PROG) || (c == C_FPUN);
    endfunction

    function automatic logic clears_upper(input cause_e c);
        return (c == C_DFAULT) || (c == C_IFAULT) || (c == C_PROG) || (c == C_FPUN);
    endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic [NCAUSE-1:0] req_i,
    input  logic [XLEN-1:0]   msr_i,
    input  logic [1:0]        prog_kind_i,
    output logic              hit_o,
    output cause_e            sel_o
);
    logic [NCAUSE-1:0] elig;
    logic              fp_drop;
    logic              ee_on;

    assign fp_drop = (prog_kind_i == 2'd0) && !msr_i[B_FE0] && !msr_i[B_FE1];
    assign ee_on   = msr_i[B_EE];

    generate
        for (genvar g = 0; g < NCAUSE; g++) begin : g_elig
            if (g == int'(C_MCHK)) begin : g_mchk
                assign elig[g] = req_i[g] && msr_i[B_ME];
            end else if (g == int'(C_EXT) || g == int'(C_DEC)) begin : g_mask
                assign elig[g] = req_i[g] && ee_on;
            end else if (g == int'(C_PROG)) begin : g_prog
                assign elig[g] = req_i[g] && !fp_drop;
            end else begin : g_plain
                assign elig[g] = req_i[g];
            end
        end
    endgenerate

    always_comb begin
        hit_o = 1'b0;
        sel_o = C_RESET;
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (elig[PRIO[i]]) begin
                hit_o = 1'b1;
                sel_o = cause_e'(PRIO[i]);
            end
        end
    end
endmodule

// File: rtl/exc_frame_former.sv
module exc_frame_former
    import exc_pkg::*;
(
    input  cause_e          sel_i,
    input  logic [XLEN-1:0] pc_next_i,
    input  logic [XLEN-1:0] msr_i,
    input  logic [1:0]      prog_kind_i,
    input  logic [1:0]      fault_code_i,
    input  logic            fault_store_i,
    output logic [XLEN-1:0] srr0_o,
    output logic [XLEN-1:0] srr1_o,
    output logic [XLEN-1:0] msr_new_o,
    output logic [XLEN-1:0] vector_o,
    output logic [XLEN-1:0] dsisr_o
);
    logic [XLEN-1:0] fw;
    logic [XLEN-1:0] kept;

    assign fw = fault_word(fault_code_i);

    always_comb begin
        srr0_o = saves_current(sel_i) ? pc_next_i - XLEN'(4) : pc_next_i;
        kept   = clears_upper(sel_i) ? (msr_i & LOW_HALF) : msr_i;
        unique case (sel_i)
            C_IFAULT: srr1_o = kept | fw;
            C_PROG:   srr1_o = kept | PROG_BASE | prog_bit(prog_kind_i);
            default:  srr1_o = kept;
        endcase
    end

    always_comb begin
        msr_new_o       = msr_i & ~ENTRY_CLR;
        msr_new_o[B_LE] = msr_i[B_ILE];
        if (sel_i == C_MCHK) begin
            msr_new_o[B_ME] = 1'b0;
        end
    end

    assign vector_o = vec_of(sel_i);
    assign dsisr_o  = fw | (fault_store_i ? STORE_BIT : '0);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              entry_stb_i,
    input  logic [NCAUSE-1:0] req_i,
    input  logic [1:0]        prog_kind_i,
    input  logic [1:0]        fault_code_i,
    input  logic              fault_store_i,
    input  logic [XLEN-1:0]   pc_next_i,
    input  logic [XLEN-1:0]   msr_i,
    output logic              taken_o,
    output logic [XLEN-1:0]   vector_o,
    output logic [XLEN-1:0]   srr0_o,
    output logic [XLEN-1:0]   srr1_o,
    output logic [XLEN-1:0]   msr_new_o,
    output logic [XLEN-1:0]   dsisr_o
);
    typedef enum logic { ST_IDLE, ST_ENTERED } state_e;

    state_e state_q, state_d;
    logic   hit;
    cause_e sel;
    logic   accept;
    logic [XLEN-1:0] f_srr0, f_srr1, f_msr, f_vec, f_dsisr;

    exc_arbiter u_arb (
        .req_i       (req_i),
        .msr_i       (msr_i),
        .prog_kind_i (prog_kind_i),
        .hit_o       (hit),
        .sel_o       (sel)
    );

    exc_frame_former u_form (
        .sel_i         (sel),
        .pc_next_i     (pc_next_i),
        .msr_i         (msr_i),
        .prog_kind_i   (prog_kind_i),
        .fault_code_i  (fault_code_i),
        .fault_store_i (fault_store_i),
        .srr0_o        (f_srr0),
        .srr1_o        (f_srr1),
        .msr_new_o     (f_msr),
        .vector_o      (f_vec),
        .dsisr_o       (f_dsisr)
    );

    assign accept = entry_stb_i && hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_ENTERED;
            ST_ENTERED: state_d = accept ? ST_ENTERED : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vector_o  <= '0;
            srr0_o    <= '0;
            srr1_o    <= '0;
            msr_new_o <= '0;
            dsisr_o   <= '0;
        end else if (accept) begin
            vector_o  <= f_vec;
            srr0_o    <= f_srr0;
            srr1_o    <= f_srr1;
            msr_new_o <= f_msr;
            if (sel == C_DFAULT) dsisr_o <= f_dsisr;
        end
    end

    assign taken_o = (state_q == ST_ENTERED);
endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
    import exc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              entry_stb_i,
    input logic [NCAUSE-1:0] req_i,
    input logic [1:0]        prog_kind_i,
    input logic [XLEN-1:0]   msr_i,
    input logic              taken_o,
    input logic [XLEN-1:0]   vector_o,
    input logic [XLEN-1:0]   srr0_o,
    input logic [XLEN-1:0]   srr1_o,
    input logic [XLEN-1:0]   msr_new_o,
    input logic [XLEN-1:0]   dsisr_o
);
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !entry_stb_i |=> !taken_o); // R11
    AST_HOLD_WHEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !taken_o |-> ($stable(srr0_o) && $stable(srr1_o) && $stable(vector_o) && $stable(msr_new_o))); // R11
    AST_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_stb_i && req_i[0]) |=> (taken_o && vector_o == 32'h100)); // R2
    AST_MASKED_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_stb_i && !msr_i[B_EE] && ((req_i & ~10'h110) == '0)) |=> !taken_o); // R7
    AST_FP_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (entry_stb_i && req_i == 10'h040 && prog_kind_i == 2'd0 && !msr_i[B_FE0] && !msr_i[B_FE1]) |=> !taken_o); // R6
    AST_ENTRY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> ((msr_new_o & ENTRY_CLR) == '0 && msr_new_o[B_LE] == $past(msr_i[B_ILE]))); // R8
    AST_MCHK_NEEDS_ME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_o && vector_o == 32'h200) |-> ($past(msr_i[B_ME]) && !msr_new_o[B_ME])); // R9
    AST_DSISR_ONLY_DFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(taken_o && vector_o == 32'h300) |-> $stable(dsisr_o)); // R10
endmodule

bind exc_entry_seq exc_entry_checker u_exc_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entry_stb_i (entry_stb_i),
    .req_i       (req_i),
    .prog_kind_i (prog_kind_i),
    .msr_i       (msr_i),
    .taken_o     (taken_o),
    .vector_o    (vector_o),
    .srr0_o      (srr0_o),
    .srr1_o      (srr1_o),
    .msr_new_o   (msr_new_o),
    .dsisr_o     (dsisr_o)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic [9:0]  req = '0;
    logic [1:0]  pk = '0, fc = '0;
    logic        fst = 1'b0;
    logic [31:0] pc = '0, msr = '0;
    logic        taken;
    logic [31:0] vec, s0, s1, mnew, dsisr;

    int compared = 0, mismatched = 0, cycles = 0;
    bit done = 0;

    logic        e_taken;
    logic [31:0] e_vec, e_s0, e_s1, e_mnew, e_dsisr;
    string       cur_tag = "R12", e_tag = "R12";

    always #10 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk_i(clk), .rst_ni(rst_n), .entry_stb_i(stb), .req_i(req),
        .prog_kind_i(pk), .fault_code_i(fc), .fault_store_i(fst),
        .pc_next_i(pc), .msr_i(msr), .taken_o(taken), .vector_o(vec),
        .srr0_o(s0), .srr1_o(s1), .msr_new_o(mnew), .dsisr_o(dsisr)
    );

    function automatic int pick(input logic [9:0] r, input logic [31:0] m, input logic [1:0] k);
        if (r[0]) return 0;
        if (r[1] && m[12]) return 1;
        if (r[3]) return 3;
        if (r[2]) return 2;
        if (r[5]) return 5;
        if (r[6] && !(k == 0 && !m[11] && !m[8])) return 6;
        if (r[7]) return 7;
        if (r[9]) return 9;
        if (r[4] && m[15]) return 4;
        if (r[8] && m[15]) return 8;
        return -1;
    endfunction

    function automatic logic [31:0] fword(input logic [1:0] c);
        case (c)
            2'd1: return 32'h4000_0000;
            2'd2: return 32'h0800_0000;
            2'd3: return 32'h1000_0000;
            default: return 32'h0;
        endcase
    endfunction

    // reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_taken = 0; e_vec = 0; e_s0 = 0; e_s1 = 0; e_mnew = 0; e_dsisr = 0;
            e_tag = "R12";
        end else begin
            int c;
            c = pick(req, msr, pk);
            e_tag = cur_tag;
            if (stb && c >= 0) begin
                int vecs [10] = '{'h100, 'h200, 'h300, 'h400, 'h500, 'h600, 'h700, 'h800, 'h900, 'hC00};
                e_taken = 1;
                e_vec = vecs[c];
                e_s0 = (c == 1 || c == 5 || c == 6 || c == 7) ? pc - 4 : pc;
                e_s1 = msr;
                if (c == 2 || c == 3 || c == 6 || c == 7) e_s1[31:16] = 16'h0;
                if (c == 3) e_s1 = e_s1 | fword(fc);
                if (c == 6) e_s1 = e_s1 | 32'h0001_0000 | (32'h0010_0000 >> pk);
                e_mnew = msr;
                foreach (e_mnew[b]) if (b inside {15, 14, 13, 11, 10, 9, 8, 5, 4, 1}) e_mnew[b] = 1'b0;
                e_mnew[0] = msr[16];
                if (c == 1) e_mnew[12] = 1'b0;
                if (c == 2) e_dsisr = fword(fc) | (fst ? 32'h0200_0000 : 32'h0);
            end else begin
                e_taken = 0;
            end
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", e_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            cmp("taken", {31'h0, taken}, {31'h0, e_taken});
            cmp("vector", vec, e_vec);
            cmp("srr0", s0, e_s0);
            cmp("srr1", s1, e_s1);
            cmp("msr_new", mnew, e_mnew);
            cmp("dsisr", dsisr, e_dsisr);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic fire(input string tag, input logic [9:0] r, input logic [31:0] m,
                        input logic [1:0] k, input logic [1:0] c, input logic s,
                        input logic [31:0] p, input logic strobe = 1'b1);
        @(negedge clk);
        cur_tag = tag; req = r; msr = m; pk = k; fc = c; fst = s; pc = p; stb = strobe;
        @(negedge clk);
        stb = 0; req = '0;
        @(negedge clk);
    endtask

    localparam logic [31:0] M_ALL  = 32'hA5A5_FF73; // ILE=1, EE=1, ME=1, FE0/FE1=1
    localparam logic [31:0] M_NILE = 32'h5A5A_FF73; // ILE=0
    localparam logic [31:0] M_NEE  = 32'hA5A5_7F73; // EE=0
    localparam logic [31:0] M_NME  = 32'hA5A5_EF73; // ME=0
    localparam logic [31:0] M_NFE  = 32'hA5A5_F673; // FE0=FE1=0

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R12";
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R1 R3 R4 R8: each cause alone
        for (int i = 0; i < 10; i++)
            fire("R1", 10'(1 << i), (i % 2) ? M_NILE : M_ALL, 2'd1, 2'd1, 1'b0, 32'h1000_0040 + 32'(i * 16));
        fire("R3", 10'h020, M_ALL, 2'd0, 2'd0, 1'b0, 32'h0000_0004);
        // R5 program kinds
        for (int k = 0; k < 4; k++) fire("R5", 10'h040, M_ALL, 2'(k), 2'd0, 1'b0, 32'h2000_0100);
        // R6 FP program dropped, other kinds not
        fire("R6", 10'h040, M_NFE, 2'd0, 2'd0, 1'b0, 32'h2000_0200);
        fire("R6", 10'h040, M_NFE, 2'd3, 2'd0, 1'b0, 32'h2000_0204);
        fire("R6", 10'h040, M_NFE | 32'h100, 2'd0, 2'd0, 1'b0, 32'h2000_0208);
        // R7 masked external/decrementer then taken
        fire("R7", 10'h110, M_NEE, 2'd0, 2'd0, 1'b0, 32'h3000_0000);
        fire("R7", 10'h010, M_NEE, 2'd0, 2'd0, 1'b0, 32'h3000_0004);
        fire("R7", 10'h010, M_ALL, 2'd0, 2'd0, 1'b0, 32'h3000_0004);
        fire("R7", 10'h100, M_ALL, 2'd0, 2'd0, 1'b0, 32'h3000_0008);
        // R9 machine check needs ME
        fire("R9", 10'h002, M_NME, 2'd0, 2'd0, 1'b0, 32'h4000_0000);
        fire("R9", 10'h102, M_NME, 2'd0, 2'd0, 1'b0, 32'h4000_0010);
        fire("R9", 10'h002, M_ALL, 2'd0, 2'd0, 1'b0, 32'h4000_0020);
        // R2 priority
        fire("R2", 10'h3FF, M_ALL, 2'd2, 2'd2, 1'b1, 32'h5000_0000);
        fire("R2", 10'h3FE, M_ALL, 2'd2, 2'd2, 1'b1, 32'h5000_0010);
        fire("R2", 10'h3FC, M_ALL, 2'd2, 2'd3, 1'b1, 32'h5000_0020);
        fire("R2", 10'h3F4, M_ALL, 2'd2, 2'd1, 1'b1, 32'h5000_0030);
        fire("R2", 10'h310, M_ALL, 2'd2, 2'd1, 1'b1, 32'h5000_0040);
        fire("R2", 10'h110, M_ALL, 2'd2, 2'd1, 1'b1, 32'h5000_0050);
        fire("R2", 10'h3C0, M_NFE, 2'd0, 2'd1, 1'b1, 32'h5000_0060);
        // R10 data-fault status codes and hold
        for (int c = 0; c < 4; c++) begin
            fire("R10", 10'h004, M_ALL, 2'd0, 2'(c), 1'b1, 32'h6000_0000);
            fire("R10", 10'h004, M_ALL, 2'd0, 2'(c), 1'b0, 32'h6000_0000);
        end
        fire("R10", 10'h004, M_ALL, 2'd0, 2'd2, 1'b1, 32'h6000_0100);
        fire("R10", 10'h008, M_ALL, 2'd0, 2'd3, 1'b0, 32'h6000_0200);
        // R11 request without strobe, then back-to-back strobes
        fire("R11", 10'h200, M_ALL, 2'd0, 2'd0, 1'b0, 32'h7000_0000, 1'b0);
        @(negedge clk);
        cur_tag = "R11"; msr = M_ALL; pc = 32'h7000_0100; req = 10'h200; stb = 1;
        @(negedge clk);
        req = 10'h020; pc = 32'h7000_0200;
        @(negedge clk);
        stb = 0; req = '0;
        repeat (3) @(negedge clk);
        // R12 reset again mid-run
        cur_tag = "R12"; rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule